// File: doc/BRIEF.md
# Fractional Feedback Divider

This block sits in the feedback path of a clock synthesizer. It divides a fast oscillator-rate clock and emits a one-cycle feedback pulse at the end of every divided period. The average division ratio can be a rational number. Each period lasts either a base integer divisor or that divisor plus one input cycles. An 8-bit modulus pattern picks the length of each period. A cycle-length field says how many periods make up one full pattern cycle: the number of periods minus one. When that field is zero the ratio is a plain integer and the pattern is not used.

Software writes a new divisor, cycle length and pattern through a load strobe. The values are held in a staging set. They reach the counters only when the current pattern cycle closes, so the repeating jitter pattern never drifts and no period is cut short. A wrap marker pulses together with the feedback pulse that ends each pattern cycle. The phase detector uses these pulses to compare against the reference.

Top module: `frac_fb_div`

## Requirements
- R1: While `rst_n` is low, `fb_pulse` and `wrap_pulse` are both 0.
- R2: With a cycle length L (`ld_last`) above zero, period number i of a pattern cycle (i = 0 first, up to L) lasts D+1 input cycles when bit i of the pattern is 1, and D cycles when it is 0. D is the divisor (`ld_div`). Period length is the number of clock cycles from one `fb_pulse` to the next.
- R3: With L equal to zero, every period lasts exactly D cycles, whatever the pattern bits are.
- R4: `wrap_pulse` is high for one cycle after every L+1 periods. It is high only in the same cycle as the `fb_pulse` that ends the last period of a pattern cycle.
- R5: `fb_pulse` is high for a single cycle at the end of each period.
- R6: Values loaded with `ld_stb` take effect only at the start of the pattern cycle that follows the next wrap. The pattern cycle that is running when the load happens completes with its old values.
- R7: When several loads happen within one pattern cycle, only the last one takes effect at the wrap.
- R8: The divisor must be at least 2. A divisor of 2 gives periods of 2 cycles, or 3 cycles for a pattern bit of 1.
- R9: After reset the block runs as an integer divider with the default divisor `RST_DIV` (5) and a cycle length of zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_vco | input | 1 | Fast clock to be divided |
| rst_n | input | 1 | Active-low reset. It asserts asynchronously and is released synchronously inside the block |
| ld_stb | input | 1 | One-cycle strobe that captures `ld_div`, `ld_last` and `ld_pat` into the staging set |
| ld_div | input | 8 | Integer divisor D, at least 2 |
| ld_last | input | 3 | Pattern cycle length minus one (L) |
| ld_pat | input | 8 | Modulus pattern. Bit i adds one cycle to period i |
| fb_pulse | output | 1 | One-cycle pulse at the end of each divided period |
| wrap_pulse | output | 1 | One-cycle pulse with the last feedback pulse of each pattern cycle |

## Verification
The checker assumes that every divisor presented with a load strobe is at least 2. Under that assumption no two feedback pulses can fall in adjacent cycles, and every period is exactly as long as the length the sequencer chose for it. It also takes for granted that the load fields are stable in the cycle the strobe is high. The stimulus only ever loads divisors of 2 or more and drives all fields together with the strobe on the falling edge. It places a second load in the same pattern cycle only when the running cycle is long enough that no wrap can fall between the two strobes.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;
  localparam int FD_DIV_W = 8;
  localparam int FD_PAT_N = 8;
  localparam int FD_PTR_W = $clog2(FD_PAT_N);
  localparam int FD_LEN_W = FD_DIV_W + 1;

  typedef struct packed {
    logic [FD_DIV_W-1:0] div;
    logic [FD_PTR_W-1:0] last;
    logic [FD_PAT_N-1:0] pat;
  } fdiv_cfg_t;
endpackage

// File: rtl/fdiv_rst_sync.sv
module fdiv_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  generate
    if (STAGES < 2) begin : g_one
      logic q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= 1'b0;
        else        q <= 1'b1;
      end
      assign rst_sync_n = q;
    end else begin : g_chain
      logic [STAGES-1:0] sh_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
      end
      assign rst_sync_n = sh_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/fdiv_cfg_bank.sv
module fdiv_cfg_bank
  import fdiv_pkg::*;
#(
  parameter int RST_DIV = 5
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      ld_stb,
  input  fdiv_cfg_t ld_cfg,
  input  logic      apply,
  output fdiv_cfg_t act_cfg
);
  localparam fdiv_cfg_t CFG_DEF = '{div: RST_DIV[FD_DIV_W-1:0], last: '0, pat: '0};

  fdiv_cfg_t stage_q, act_q;
  logic      pend_q, pend_d;
  logic      stage_en, act_en;

  // clock enables
  assign stage_en = ld_stb;
  assign act_en   = apply & pend_q;

  // next-state for the pending flag: a new load wins over a concurrent apply
  always_comb begin
    pend_d = pend_q;
    if (act_en) pend_d = 1'b0;
    if (ld_stb) pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        stage_q <= CFG_DEF;
    else if (stage_en) stage_q <= ld_cfg;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      act_q <= CFG_DEF;
    else if (act_en) act_q <= stage_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  assign act_cfg = act_q;
endmodule

// File: rtl/fdiv_pat_seq.sv
module fdiv_pat_seq
  import fdiv_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                eop,
  input  fdiv_cfg_t           cfg,
  output logic [FD_LEN_W-1:0] len,
  output logic                wrap_now
);
  logic [FD_PTR_W-1:0] ptr_q, ptr_d;
  logic [FD_PAT_N-1:0] sel_oh;
  logic                frac_bit;
  logic                at_last;

  // one-hot decode of the pointer, masked with the pattern
  generate
    for (genvar gi = 0; gi < FD_PAT_N; gi++) begin : g_sel
      assign sel_oh[gi] = (ptr_q == FD_PTR_W'(gi)) & cfg.pat[gi];
    end
  endgenerate

  assign frac_bit = (cfg.last != '0) & (|sel_oh);
  assign len      = {1'b0, cfg.div} + {{(FD_LEN_W-1){1'b0}}, frac_bit};
  assign at_last  = (ptr_q >= cfg.last);
  assign wrap_now = eop & at_last;

  always_comb begin
    ptr_d = ptr_q;
    if (eop) begin
      if (at_last) ptr_d = '0;
      else         ptr_d = ptr_q + FD_PTR_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   ptr_q <= '0;
    else if (eop) ptr_q <= ptr_d;
  end
endmodule

// File: rtl/fdiv_period_ctr.sv
module fdiv_period_ctr
  import fdiv_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [FD_LEN_W-1:0] len,
  output logic                eop
);
  logic [FD_LEN_W-1:0] cnt_q, cnt_d;

  assign eop = (cnt_q >= (len - FD_LEN_W'(1)));

  always_comb begin
    if (eop) cnt_d = '0;
    else     cnt_d = cnt_q + FD_LEN_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/frac_fb_div.sv
module frac_fb_div
  import fdiv_pkg::*;
#(
  parameter int RST_DIV     = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk_vco,
  input  logic                rst_n,
  input  logic                ld_stb,
  input  logic [FD_DIV_W-1:0] ld_div,
  input  logic [FD_PTR_W-1:0] ld_last,
  input  logic [FD_PAT_N-1:0] ld_pat,
  output logic                fb_pulse,
  output logic                wrap_pulse
);
  logic                rst_i_n;
  fdiv_cfg_t           ld_cfg, act_cfg;
  logic                eop, wrap_now;
  logic [FD_LEN_W-1:0] cur_len;
  logic [FD_PTR_W-1:0] act_last;
  logic                fb_q, wrap_q;

  assign ld_cfg   = '{div: ld_div, last: ld_last, pat: ld_pat};
  assign act_last = act_cfg.last;

  fdiv_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk_vco), .rst_n(rst_n), .rst_sync_n(rst_i_n)
  );

  fdiv_cfg_bank #(.RST_DIV(RST_DIV)) u_cfg (
    .clk(clk_vco), .rst_n(rst_i_n), .ld_stb(ld_stb), .ld_cfg(ld_cfg),
    .apply(wrap_now), .act_cfg(act_cfg)
  );

  fdiv_pat_seq u_seq (
    .clk(clk_vco), .rst_n(rst_i_n), .eop(eop), .cfg(act_cfg),
    .len(cur_len), .wrap_now(wrap_now)
  );

  fdiv_period_ctr u_ctr (
    .clk(clk_vco), .rst_n(rst_i_n), .len(cur_len), .eop(eop)
  );

  always_ff @(posedge clk_vco or negedge rst_i_n) begin
    if (!rst_i_n) begin
      fb_q   <= 1'b0;
      wrap_q <= 1'b0;
    end else begin
      fb_q   <= eop;
      wrap_q <= wrap_now;
    end
  end

  assign fb_pulse   = fb_q;
  assign wrap_pulse = wrap_q;
endmodule

// File: rtl/fdiv_chk.sv
module fdiv_chk
  import fdiv_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                ld_stb,
  input logic [FD_DIV_W-1:0] ld_div,
  input logic                fb_pulse,
  input logic                wrap_pulse,
  input logic [FD_LEN_W-1:0] cur_len,
  input logic [FD_PTR_W-1:0] act_last
);
  logic [FD_LEN_W:0] gap_q;
  logic              gap_ok;
  logic [FD_PTR_W:0] fbc_q;
  logic              wrap_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q   <= '0;
      gap_ok  <= 1'b0;
      fbc_q   <= '0;
      wrap_ok <= 1'b0;
    end else begin
      if (fb_pulse) begin
        gap_q  <= (FD_LEN_W+1)'(1);
        gap_ok <= 1'b1;
      end else if (gap_q != '1) begin
        gap_q <= gap_q + (FD_LEN_W+1)'(1);
      end
      if (wrap_pulse) begin
        fbc_q   <= '0;
        wrap_ok <= 1'b1;
      end else if (fb_pulse) begin
        fbc_q <= fbc_q + (FD_PTR_W+1)'(1);
      end
    end
  end

  AST_MIN_DIVISOR: assert property (@(posedge clk) disable iff (!rst_n)
    ld_stb |-> (ld_div >= FD_DIV_W'(2))); // R8

  AST_SINGLE_FB: assert property (@(posedge clk) disable iff (!rst_n)
    fb_pulse |=> !fb_pulse); // R5

  AST_WRAP_ON_FB: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_pulse |-> fb_pulse); // R4

  AST_PERIOD_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (fb_pulse && gap_ok) |-> (gap_q == {1'b0, $past(cur_len)})); // R2

  AST_WRAP_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_pulse && wrap_ok) |-> (fbc_q == {1'b0, $past(act_last)})); // R4
endmodule

bind frac_fb_div fdiv_chk u_chk (
  .clk(clk_vco), .rst_n(rst_n), .ld_stb(ld_stb), .ld_div(ld_div),
  .fb_pulse(fb_pulse), .wrap_pulse(wrap_pulse),
  .cur_len(cur_len), .act_last(act_last)
);

// File: tb/sim_frac_fb_div.sv
module sim_frac_fb_div;
  import fdiv_pkg::*;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       ld_stb;
  logic [7:0] ld_div;
  logic [2:0] ld_last;
  logic [7:0] ld_pat;
  logic       fb_pulse, wrap_pulse;

  always #2.5 clk = ~clk;

  frac_fb_div u0 (
    .clk_vco(clk), .rst_n(rst_n), .ld_stb(ld_stb), .ld_div(ld_div),
    .ld_last(ld_last), .ld_pat(ld_pat), .fb_pulse(fb_pulse), .wrap_pulse(wrap_pulse)
  );

  typedef struct {
    int    len;
    bit    wrap;
    string req;
  } exp_t;

  exp_t  sb[$];
  int    checks = 0;
  int    fails  = 0;
  int    cyc    = 0;
  int    prev   = 0;
  bit    started = 1'b0;
  bit    timeout = 1'b0;
  int    cur_div, cur_last, cur_pat;
  string old_req;

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // expected period lengths of one whole pattern cycle (R2, R3)
  task automatic push_cycle(int div, int last, int pat, string req);
    for (int i = 0; i <= last; i++) begin
      exp_t e;
      e.len  = (last == 0) ? div : div + ((pat >> i) & 1);
      e.wrap = (i == last);
      e.req  = req;
      sb.push_back(e);
    end
  endtask

  // monitor: measure each period and compare it with the scoreboard
  always @(negedge clk) begin
    exp_t e;
    cyc++;
    if (rst_n && wrap_pulse && !fb_pulse) check(1'b0, "R4", "wrap without fb", 1, 0);
    if (rst_n && fb_pulse) begin
      if (!started) begin
        started = 1'b1;
      end else if (sb.size() == 0) begin
        check(1'b0, "R5", "unexpected fb pulse", cyc - prev, 0);
      end else begin
        e = sb.pop_front();
        check((cyc - prev) == e.len, e.req, "period length", cyc - prev, e.len);
        check(wrap_pulse == e.wrap, e.req, "wrap marker", int'(wrap_pulse), int'(e.wrap));
      end
      prev = cyc;
    end
  end

  task automatic wait_wrap();
    do @(negedge clk); while (!wrap_pulse);
  endtask

  task automatic load(int div, int last, int pat);
    ld_div  = 8'(div);
    ld_last = 3'(last);
    ld_pat  = 8'(pat);
    ld_stb  = 1'b1;
    @(negedge clk);
    ld_stb  = 1'b0;
  endtask

  // called at the falling edge that shows a wrap marker
  task automatic run_cfg(int div, int last, int pat, int ncyc, string req, bit junk_first);
    if (junk_first) load(9, 5, 'h3C);   // R7: overwritten before the wrap
    load(div, last, pat);
    push_cycle(cur_div, cur_last, cur_pat, old_req);   // R6: running cycle finishes
    old_req = "R6";
    for (int k = 0; k < ncyc; k++) push_cycle(div, last, pat, req);
    cur_div  = div;
    cur_last = last;
    cur_pat  = pat;
    repeat (1 + ncyc) wait_wrap();
  endtask

  task automatic run_all();
    rst_n   = 1'b0;
    ld_stb  = 1'b0;
    ld_div  = 8'd0;
    ld_last = 3'd0;
    ld_pat  = 8'd0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(!fb_pulse && !wrap_pulse, "R1", "outputs in reset",
            int'({fb_pulse, wrap_pulse}), 0);
    end
    rst_n = 1'b1;
    cur_div  = 5;   // R9 default
    cur_last = 0;
    cur_pat  = 0;
    old_req  = "R9";
    wait_wrap();
    run_cfg(3, 0, 'hFF, 3, "R3", 1'b0);
    run_cfg(4, 2, 'b101, 2, "R2", 1'b0);
    run_cfg(2, 0, 'h00, 3, "R8", 1'b0);
    run_cfg(6, 7, 'hA5, 2, "R2", 1'b0);
    run_cfg(7, 3, 'hF0, 2, "R4", 1'b0);
    run_cfg(3, 1, 'b10, 2, "R7", 1'b1);
    run_cfg(2, 1, 'b11, 2, "R8", 1'b0);
    run_cfg(5, 0, 'h00, 1, "R5", 1'b0);
    @(negedge clk);
    check(sb.size() == 0, "R4", "scoreboard drained", sb.size(), 0);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (20000) @(posedge clk);
        timeout = 1'b1;
      end
    join_any
    disable fork;
    if (timeout) check(1'b0, "R5", "watchdog expired", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule